// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block watches the asynchronous control and data lines of a parallel flash device through the system clock and decides which bus cycles are command writes. It follows the unlock-prefixed command sequences that software issues, keeps track of whether the device is in array-read, identification-read (autoselect) or unlock-bypass mode, and hands each completed program command to the program engine as a one-cycle request that carries the target address and data. The program and erase algorithms themselves sit outside this block.

In identification mode, qualified read cycles are answered from a four-entry code register file instead of the array. The answer is selected by the two low address bits. An accelerate input puts the decoder into unlock-bypass mode, so that a program needs only two writes. While that input is asserted, the effective sector-group protection flags are cleared. Releasing the input returns the decoder to array-read mode and restores the protection flags.

Top module: `flash_cmd_decoder`

## Requirements
- R1: A write is taken only on the first clock edge at which ce_n=0, we_n=0 and oe_n=1 all hold. A we_n-low period that lasts several clocks counts as one write, and a cycle with oe_n=0 or ce_n=1 is ignored.
- R2: A standard program is four writes: 0xAA to address 0x555, then 0x55 to 0x2AA, then 0xA0 to 0x555, then the target address and data. Unlock addresses compare the low 11 address bits, and command codes use wdata[7:0]. After the fourth write the decoder returns to array-read mode.
- R3: 0xAA to 0x555, then 0x55 to 0x2AA, then 0x20 to 0x555 enters bypass mode. In bypass mode, 0xA0 to any address followed by the address and data issues a program request, and the decoder stays in bypass mode. 0x90 followed by 0x00 leaves bypass mode for array-read mode.
- R4: 0xAA to 0x555, then 0x55 to 0x2AA, then 0x90 to 0x555 enters autoselect mode. In autoselect mode, a read cycle (ce_n=0, oe_n=0, we_n=1) raises id_sel, and id_data carries the code byte selected by addr[1:0]: byte i of ID_CODES is bits 8i+7 to 8i. In every other mode id_sel and id_data are 0.
- R5: A write that does not match the expected step of a sequence abandons the sequence, returns the decoder to array-read mode, and issues no program request.
- R6: A write with data 0xF0 at any step returns the decoder to array-read mode. The one exception is the address/data write of a program, where 0xF0 is taken as program data.
- R7: When accel is sampled high, bypass mode is in effect from the next cycle and holds for as long as accel stays high, and two-write programs are accepted. One cycle after accel is sampled low again, following a high sample, the decoder is in array-read mode.
- R8: prot_eff is all zeros in the cycle after accel is sampled high. In every other cycle it equals prot_in as sampled at the previous clock.
- R9: pgm_req is high for exactly one cycle, the cycle after the final write edge of a program, and pgm_addr and pgm_data hold that write's address and data during that cycle.
- R10: mode reads 2'b00 for array read, 2'b01 for autoselect and 2'b10 for bypass, and never 2'b11. Reset gives array-read mode with pgm_req low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Word address |
| wdata | input | DATA_W | Write data |
| accel | input | 1 | Accelerated-program request |
| prot_in | input | NGROUP | Stored sector-group protection flags |
| pgm_req | output | 1 | One-cycle program request strobe |
| pgm_addr | output | ADDR_W | Address of the requested program |
| pgm_data | output | DATA_W | Data of the requested program |
| mode | output | 2 | Current mode: 00 read, 01 autoselect, 10 bypass |
| id_sel | output | 1 | Identification code is being read |
| id_data | output | 8 | Identification code byte |
| prot_eff | output | NGROUP | Protection flags in effect |

## Verification
The bench holds we_n low for several clocks during a write. A decoder that counted every low clock would see a repeated unlock write and abort the sequence. It also runs a full program sequence with oe_n low and again with ce_n high, where a decoder that ignored the qualifiers would issue a spurious request. Other directed cases cover a program whose data is 0xF0, which a decoder applying the reset code too broadly would drop; a broken unlock followed by a lone second unlock step, which must not program; an accelerate pulse that overrides a pending bypass exit; and identification reads at every index.

// File: rtl/fcd_pkg.sv
package fcd_pkg;

    typedef enum logic [1:0] {
        MODE_READ = 2'b00,
        MODE_AUTO = 2'b01,
        MODE_BYP  = 2'b10
    } mode_e;

    typedef enum logic [2:0] {
        S_READ,
        S_UNLK1,
        S_UNLK2,
        S_PGM,
        S_AUTO,
        S_BYP,
        S_BYP_PGM,
        S_BYP_EXIT
    } seq_e;

    localparam int UNLK_W = 11;
    localparam logic [UNLK_W-1:0] ADDR_FIRST  = 11'h555;
    localparam logic [UNLK_W-1:0] ADDR_SECOND = 11'h2AA;

    localparam logic [7:0] CODE_KEY1  = 8'hAA;
    localparam logic [7:0] CODE_KEY2  = 8'h55;
    localparam logic [7:0] CODE_PGM   = 8'hA0;
    localparam logic [7:0] CODE_BYP   = 8'h20;
    localparam logic [7:0] CODE_AUTO  = 8'h90;
    localparam logic [7:0] CODE_RESET = 8'hF0;

    function automatic logic in_bypass(seq_e s);
        return (s == S_BYP) || (s == S_BYP_PGM) || (s == S_BYP_EXIT);
    endfunction

    function automatic mode_e mode_of(seq_e s);
        if (in_bypass(s))
            return MODE_BYP;
        else if (s == S_AUTO)
            return MODE_AUTO;
        else
            return MODE_READ;
    endfunction

endpackage

// File: rtl/fcd_write_detect.sv
module fcd_write_detect (
    input  logic clk,
    input  logic rst,
    input  logic ce_n,
    input  logic we_n,
    input  logic oe_n,
    output logic wr_stb,
    output logic rd_act
);
    logic wr_cond;
    logic wr_cond_q;

    assign wr_cond = !ce_n && !we_n && oe_n;
    assign rd_act  = !ce_n && !oe_n && we_n;
    // one strobe per write-enable low period
    assign wr_stb  = wr_cond && !wr_cond_q;

    always_ff @(posedge clk) begin
        if (rst)
            wr_cond_q <= 1'b0;
        else
            wr_cond_q <= wr_cond;
    end
endmodule

// File: rtl/fcd_seq_fsm.sv
module fcd_seq_fsm
    import fcd_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_stb,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              accel,
    output seq_e              state,
    output logic              pgm_req,
    output logic [ADDR_W-1:0] pgm_addr,
    output logic [DATA_W-1:0] pgm_data
);
    seq_e              nxt;
    logic              req_nxt;
    logic              accel_q;
    logic [7:0]        cmd;
    logic [UNLK_W-1:0] lo;

    assign cmd = wdata[7:0];
    assign lo  = addr[UNLK_W-1:0];

    always_comb begin
        nxt     = state;
        req_nxt = 1'b0;
        if (wr_stb) begin
            if (state == S_PGM || state == S_BYP_PGM) begin
                // address/data write: any value, 0xF0 included, is data
                req_nxt = 1'b1;
                nxt     = (state == S_PGM) ? S_READ : S_BYP;
            end else if (cmd == CODE_RESET) begin
                nxt = S_READ;
            end else begin
                case (state)
                    S_READ, S_AUTO:
                        nxt = (cmd == CODE_KEY1 && lo == ADDR_FIRST) ? S_UNLK1 : S_READ;
                    S_UNLK1:
                        nxt = (cmd == CODE_KEY2 && lo == ADDR_SECOND) ? S_UNLK2 : S_READ;
                    S_UNLK2: begin
                        nxt = S_READ;
                        if (lo == ADDR_FIRST) begin
                            if (cmd == CODE_PGM)       nxt = S_PGM;
                            else if (cmd == CODE_BYP)  nxt = S_BYP;
                            else if (cmd == CODE_AUTO) nxt = S_AUTO;
                        end
                    end
                    S_BYP: begin
                        if (cmd == CODE_PGM)       nxt = S_BYP_PGM;
                        else if (cmd == CODE_AUTO) nxt = S_BYP_EXIT;
                        else                       nxt = S_READ;
                    end
                    // the exit code 0x00 and any mismatch both end in read mode
                    default: nxt = S_READ;
                endcase
            end
        end
        if (accel && !in_bypass(nxt))
            nxt = S_BYP;
        else if (accel_q && !accel)
            nxt = S_READ;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= S_READ;
            accel_q  <= 1'b0;
            pgm_req  <= 1'b0;
            pgm_addr <= '0;
            pgm_data <= '0;
        end else begin
            state   <= nxt;
            accel_q <= accel;
            pgm_req <= req_nxt;
            if (req_nxt) begin
                pgm_addr <= addr;
                pgm_data <= wdata;
            end
        end
    end
endmodule

// File: rtl/fcd_id_regs.sv
module fcd_id_regs
    import fcd_pkg::*;
#(
    parameter int          NGROUP   = 8,
    parameter logic [31:0] ID_CODES = 32'h0022_7E01
) (
    input  logic              clk,
    input  logic              rst,
    input  mode_e             mode,
    input  logic              rd_act,
    input  logic [1:0]        idx,
    input  logic              accel,
    input  logic [NGROUP-1:0] prot_in,
    output logic              id_sel,
    output logic [7:0]        id_data,
    output logic [NGROUP-1:0] prot_eff
);
    localparam int NCODE = 4;

    logic [7:0] codes [NCODE];

    for (genvar g = 0; g < NCODE; g++) begin : g_code
        assign codes[g] = ID_CODES[8*g +: 8];
    end

    assign id_sel  = rd_act && (mode == MODE_AUTO);
    assign id_data = id_sel ? codes[idx] : 8'h00;

    always_ff @(posedge clk) begin
        if (rst)
            prot_eff <= '0;
        else
            prot_eff <= accel ? '0 : prot_in;
    end
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
    import fcd_pkg::*;
#(
    parameter int          ADDR_W   = 24,
    parameter int          DATA_W   = 16,
    parameter int          NGROUP   = 8,
    parameter logic [31:0] ID_CODES = 32'h0022_7E01
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              accel,
    input  logic [NGROUP-1:0] prot_in,
    output logic              pgm_req,
    output logic [ADDR_W-1:0] pgm_addr,
    output logic [DATA_W-1:0] pgm_data,
    output logic [1:0]        mode,
    output logic              id_sel,
    output logic [7:0]        id_data,
    output logic [NGROUP-1:0] prot_eff
);
    logic  wr_stb;
    logic  rd_act;
    seq_e  state;
    mode_e cur_mode;

    fcd_write_detect i_wdet (
        .clk    (clk),
        .rst    (rst),
        .ce_n   (ce_n),
        .we_n   (we_n),
        .oe_n   (oe_n),
        .wr_stb (wr_stb),
        .rd_act (rd_act)
    );

    fcd_seq_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_fsm (
        .clk      (clk),
        .rst      (rst),
        .wr_stb   (wr_stb),
        .addr     (addr),
        .wdata    (wdata),
        .accel    (accel),
        .state    (state),
        .pgm_req  (pgm_req),
        .pgm_addr (pgm_addr),
        .pgm_data (pgm_data)
    );

    assign cur_mode = mode_of(state);
    assign mode     = cur_mode;

    fcd_id_regs #(.NGROUP(NGROUP), .ID_CODES(ID_CODES)) i_id (
        .clk      (clk),
        .rst      (rst),
        .mode     (cur_mode),
        .rd_act   (rd_act),
        .idx      (addr[1:0]),
        .accel    (accel),
        .prot_in  (prot_in),
        .id_sel   (id_sel),
        .id_data  (id_data),
        .prot_eff (prot_eff)
    );
endmodule

// File: rtl/fcd_checker.sv
module fcd_checker #(
    parameter int NGROUP = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              ce_n,
    input logic              we_n,
    input logic              oe_n,
    input logic              accel,
    input logic [NGROUP-1:0] prot_in,
    input logic              pgm_req,
    input logic [1:0]        mode,
    input logic              id_sel,
    input logic [NGROUP-1:0] prot_eff
);
    logic [1:0] vcnt;

    always_ff @(posedge clk) begin
        if (rst)
            vcnt <= 2'd0;
        else if (vcnt != 2'd3)
            vcnt <= vcnt + 2'd1;
    end

    assert_req_after_write_R1: assert property (@(posedge clk) disable iff (rst)
        (vcnt != 2'd0 && pgm_req) |-> $past(!ce_n && !we_n && oe_n));

    assert_idsel_auto_R4: assert property (@(posedge clk) disable iff (rst)
        id_sel |-> (mode == 2'b01 && !ce_n && !oe_n && we_n));

    assert_accel_bypass_R7: assert property (@(posedge clk) disable iff (rst)
        (vcnt != 2'd0 && $past(accel)) |-> mode == 2'b10);

    assert_accel_release_R7: assert property (@(posedge clk) disable iff (rst)
        (vcnt >= 2'd2 && $past(accel, 2) && !$past(accel)) |-> mode == 2'b00);

    assert_prot_clear_R8: assert property (@(posedge clk) disable iff (rst)
        (vcnt != 2'd0 && $past(accel)) |-> prot_eff == '0);

    assert_prot_follow_R8: assert property (@(posedge clk) disable iff (rst)
        (vcnt != 2'd0 && !$past(accel)) |-> prot_eff == $past(prot_in));

    assert_req_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        pgm_req |=> !pgm_req);

    assert_mode_legal_R10: assert property (@(posedge clk) disable iff (rst)
        mode != 2'b11);
endmodule

bind flash_cmd_decoder fcd_checker #(.NGROUP(NGROUP)) i_fcd_checker (
    .clk      (clk),
    .rst      (rst),
    .ce_n     (ce_n),
    .we_n     (we_n),
    .oe_n     (oe_n),
    .accel    (accel),
    .prot_in  (prot_in),
    .pgm_req  (pgm_req),
    .mode     (mode),
    .id_sel   (id_sel),
    .prot_eff (prot_eff)
);

// File: tb/test_flash_cmd_decoder.sv
`timescale 1ns/1ps
module test_flash_cmd_decoder;
    localparam int ADDR_W = 24;
    localparam int DATA_W = 16;
    localparam int NGROUP = 8;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [ADDR_W-1:0] addr = '0;
    logic [DATA_W-1:0] wdata = '0;
    logic              accel = 1'b0;
    logic [NGROUP-1:0] prot_in = 8'hA5;
    logic              pgm_req;
    logic [ADDR_W-1:0] pgm_addr;
    logic [DATA_W-1:0] pgm_data;
    logic [1:0]        mode;
    logic              id_sel;
    logic [7:0]        id_data;
    logic [NGROUP-1:0] prot_eff;

    int errors = 0;
    int checks = 0;
    int reqs = 0;
    logic [ADDR_W-1:0] last_addr = '0;
    logic [DATA_W-1:0] last_data = '0;

    always #5 clk = ~clk;

    flash_cmd_decoder i_flash_cmd_decoder (
        .clk(clk), .rst(rst), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .addr(addr), .wdata(wdata), .accel(accel), .prot_in(prot_in),
        .pgm_req(pgm_req), .pgm_addr(pgm_addr), .pgm_data(pgm_data),
        .mode(mode), .id_sel(id_sel), .id_data(id_data), .prot_eff(prot_eff)
    );

    always @(negedge clk) begin
        if (!rst && pgm_req) begin
            reqs++;
            last_addr = pgm_addr;
            last_data = pgm_data;
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [ADDR_W-1:0] a, input logic [15:0] d, input int hold = 1,
                             input logic oe_v = 1'b1, input logic ce_v = 1'b0);
        @(negedge clk);
        ce_n = ce_v; we_n = 1'b0; oe_n = oe_v; addr = a; wdata = d;
        repeat (hold) @(negedge clk);
        ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic unlock(input logic [7:0] code);
        bus_write(24'h000555, 16'h00AA);
        bus_write(24'h0002AA, 16'h0055);
        bus_write(24'h000555, {8'h00, code});
    endtask

    task automatic t_reset();
        check(mode == 2'b00, "R10 reset mode", mode, 0);
        check(pgm_req == 1'b0, "R10 reset pgm_req", pgm_req, 0);
    endtask

    task automatic t_std_program();
        int r0 = reqs;
        unlock(8'hA0);
        check(reqs == r0, "R2 no request before data write", reqs - r0, 0);
        bus_write(24'h0ABCDE, 16'h1234);
        check(reqs == r0 + 1, "R9 one request", reqs - r0, 1);
        check(last_addr == 24'h0ABCDE, "R9 pgm_addr", last_addr, 24'h0ABCDE);
        check(last_data == 16'h1234, "R9 pgm_data", last_data, 16'h1234);
        check(mode == 2'b00, "R2 back to read", mode, 0);
    endtask

    task automatic t_autoselect();
        logic [7:0] exp_codes [4];
        exp_codes[0] = 8'h01; exp_codes[1] = 8'h7E; exp_codes[2] = 8'h22; exp_codes[3] = 8'h00;
        @(negedge clk); ce_n = 1'b0; oe_n = 1'b0; addr = 24'h1; #1;
        check(id_sel == 1'b0, "R4 no id read in read mode", id_sel, 0);
        @(negedge clk); ce_n = 1'b1; oe_n = 1'b1;
        unlock(8'h90);
        check(mode == 2'b01, "R4 autoselect mode", mode, 1);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk); ce_n = 1'b0; oe_n = 1'b0; addr = 24'(i); #1;
            check(id_sel == 1'b1, "R4 id_sel", id_sel, 1);
            check(id_data == exp_codes[i], "R4 id_data", id_data, exp_codes[i]);
        end
        @(negedge clk); ce_n = 1'b1; oe_n = 1'b1;
        check(mode == 2'b01, "R4 mode held across reads", mode, 1);
        bus_write(24'h0, 16'h00F0);
        check(mode == 2'b00, "R6 reset code leaves autoselect", mode, 0);
    endtask

    task automatic t_bypass();
        int r0 = reqs;
        unlock(8'h20);
        check(mode == 2'b10, "R3 bypass entered", mode, 2);
        bus_write(24'h777777, 16'h00A0);
        bus_write(24'h012345, 16'hBEEF);
        check(reqs == r0 + 1, "R3 two-write program", reqs - r0, 1);
        check(last_data == 16'hBEEF, "R3 bypass data", last_data, 16'hBEEF);
        check(mode == 2'b10, "R3 stays bypass", mode, 2);
        bus_write(24'h0, 16'h0090);
        check(mode == 2'b10, "R3 still bypass mid exit", mode, 2);
        bus_write(24'h0, 16'h0000);
        check(mode == 2'b00, "R3 bypass exit", mode, 0);
    endtask

    task automatic t_abort();
        int r0 = reqs;
        bus_write(24'h000555, 16'h00AA);
        bus_write(24'h0002AA, 16'h0011);
        check(mode == 2'b00, "R5 mode after mismatch", mode, 0);
        bus_write(24'h0002AA, 16'h0055);
        bus_write(24'h000555, 16'h00A0);
        bus_write(24'h000100, 16'h5555);
        check(reqs == r0, "R5 no request after abort", reqs - r0, 0);
        bus_write(24'h000555, 16'h00AA);
        bus_write(24'h0002AA, 16'h00F0);
        bus_write(24'h000555, 16'h00A0);
        bus_write(24'h000100, 16'h5555);
        check(reqs == r0, "R6 reset code mid unlock", reqs - r0, 0);
        unlock(8'h20);
        bus_write(24'h0, 16'h00F0);
        check(mode == 2'b00, "R6 reset code leaves bypass", mode, 0);
    endtask

    task automatic t_f0_data();
        int r0 = reqs;
        unlock(8'hA0);
        bus_write(24'h000200, 16'h00F0);
        check(reqs == r0 + 1 && last_data == 16'h00F0, "R6 0xF0 as program data", last_data, 16'h00F0);
    endtask

    task automatic t_qualify();
        int r0 = reqs;
        bus_write(24'h000555, 16'h00AA, 1, 1'b0);
        bus_write(24'h0002AA, 16'h0055, 1, 1'b0);
        bus_write(24'h000555, 16'h00A0, 1, 1'b0);
        bus_write(24'h000300, 16'h1111, 1, 1'b0);
        check(reqs == r0, "R1 oe_n low ignored", reqs - r0, 0);
        bus_write(24'h000555, 16'h00AA, 1, 1'b1, 1'b1);
        bus_write(24'h0002AA, 16'h0055, 1, 1'b1, 1'b1);
        bus_write(24'h000555, 16'h00A0, 1, 1'b1, 1'b1);
        bus_write(24'h000300, 16'h2222, 1, 1'b1, 1'b1);
        check(reqs == r0, "R1 ce_n high ignored", reqs - r0, 0);
        bus_write(24'h000555, 16'h00AA, 4);
        bus_write(24'h0002AA, 16'h0055, 3);
        bus_write(24'h000555, 16'h00A0, 2);
        bus_write(24'h000300, 16'h3333, 5);
        check(reqs == r0 + 1, "R1 long write counted once", reqs - r0, 1);
    endtask

    task automatic t_accel();
        int r0 = reqs;
        check(prot_eff == 8'hA5, "R8 protection follows input", prot_eff, 8'hA5);
        unlock(8'h20);
        bus_write(24'h0, 16'h0090);
        @(negedge clk); accel = 1'b1;
        @(negedge clk);
        check(mode == 2'b10, "R7 accel forces bypass", mode, 2);
        check(prot_eff == 8'h00, "R8 protection cleared", prot_eff, 0);
        bus_write(24'h0, 16'h0000);
        check(mode == 2'b10, "R7 bypass held under accel", mode, 2);
        bus_write(24'h0, 16'h00A0);
        bus_write(24'h004444, 16'h4444);
        check(reqs == r0 + 1 && last_addr == 24'h004444, "R7 program under accel", last_addr, 24'h004444);
        @(negedge clk); accel = 1'b0;
        @(negedge clk);
        check(mode == 2'b00, "R7 release to read", mode, 0);
        check(prot_eff == 8'hA5, "R8 protection restored", prot_eff, 8'hA5);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_std_program();
        t_autoselect();
        t_bypass();
        t_abort();
        t_f0_data();
        t_qualify();
        t_accel();
        repeat (3) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule